// File: doc/BRIEF.md
# Interlaced Half-Line Field Sequencer

This block walks a video frame one half-line at a time. A frame is two fields, the odd field first and then the even field. Each field has its own length, built from a shared equalisation count, a shared active-line count, and per-field pre-blanking and post-blanking half-line counts. Because everything is counted in half-lines, interlaced timing (odd half-line totals) and double-strike timing (even totals) come from the same sums.

The sequencer marks where each field's active region begins and ends with single-cycle pulses tagged odd or even. It reports the vertical beam position and a clamped horizontal beam position, which counts sample ticks from the start of the current full line. It also issues poll strobes for an input-sampling engine at a fixed distance after each field boundary, and then at a programmable line interval. The timing values sit in a shadow register set loaded by a write strobe, and all field boundaries are derived from it combinationally.

Top module: `hlseq_top`

## Requirements
- R1: After reset the timing set holds equalisation 6, active lines 0, odd pre-blank 502, odd post-blank 5, even pre-blank 503, even post-blank 4, half-line width 429, poll interval 64 lines. So the odd field is 525 half-lines long and the frame is 1050. Also after reset the counter is 0, `vPos` is 1, `hPos` is 1 and no pulse is active.
- R2: A field spans 3*EQU + PRE + 2*ACT + POST half-lines, using that field's own PRE and POST. `fieldEven` is 0 while the counter is below the odd-field total and 1 otherwise.
- R3: `halfLineIdx` advances by one on each `hlTick` and does not move without one. From the last half-line of the frame (odd total + even total - 1) it returns to 0. A counter at or above that value after a shrinking write also returns to 0.
- R4: When ACT is nonzero, `fieldBegin` pulses for one cycle as the counter becomes 3*EQU + odd PRE, with `eventEven`=0. `fieldEnd` pulses with `eventEven`=0 as the counter leaves that index + 2*ACT - 1.
- R5: When ACT is nonzero, `fieldBegin` pulses as the counter becomes 3*EQU + even PRE + odd total, with `eventEven`=1. `fieldEnd` pulses with `eventEven`=1 as the counter leaves that index + 2*ACT - 1.
- R6: With ACT = 0, neither `fieldBegin` nor `fieldEnd` ever pulses.
- R7: `vPos` equals 1 + `halfLineIdx`/2 (integer division).
- R8: `hPos` equals 1 + the number of `smpTick` pulses since the counter last became even, clamped to the range 1 to 2*HLW.
- R9: `pollStrobe` pulses as the counter becomes 15 and as it becomes odd total + 15. Within a field it pulses again every 2*N half-lines, where N is the poll interval. A field boundary cancels any pending poll and schedules the first poll of the new field.
- R10: `cfgWr` loads all timing fields at once. The new values govern the very next `hlTick`, and the write itself does not move `halfLineIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hlTick | input | 1 | One-cycle pulse per elapsed half-line |
| smpTick | input | 1 | One-cycle pulse per video sample |
| cfgWr | input | 1 | Load strobe for the timing fields below |
| cfgEqu | input | 4 | Equalisation count (x3 half-lines) |
| cfgActive | input | 10 | Active lines per field (x2 half-lines) |
| cfgOddPre | input | 10 | Odd-field pre-blank half-lines |
| cfgOddPost | input | 10 | Odd-field post-blank half-lines |
| cfgEvenPre | input | 10 | Even-field pre-blank half-lines |
| cfgEvenPost | input | 10 | Even-field post-blank half-lines |
| cfgHalfWidth | input | 10 | Samples per half-line (HLW) |
| cfgPollLines | input | 10 | Poll interval in full lines |
| halfLineIdx | output | 12 | Current half-line within the frame |
| vPos | output | 12 | Vertical beam position |
| hPos | output | 11 | Horizontal beam position |
| fieldEven | output | 1 | 0 in odd field, 1 in even field |
| fieldBegin | output | 1 | Active region start pulse |
| fieldEnd | output | 1 | Active region end pulse |
| eventEven | output | 1 | Field tag of the latest begin/end pulse |
| pollStrobe | output | 1 | Poll request pulse |

## Verification
The counter, `fieldEven`, `vPos`, the begin/end/poll pulses and `eventEven` all register on the clock edge that samples `hlTick`. Each is therefore due one edge after the tick, and the pulses drop one edge later. `hPos` moves on the edge that samples `smpTick`, or is cleared on the edge where the counter turns even. The bench drives every input on the falling edge and holds it for one cycle. It then reads all outputs on the next falling edge, which is the single cycle in which a pulse is visible. It compares them against a model built only from the field formulas.

// File: rtl/hlseq_pkg.sv
package hlseq_pkg;
  localparam int DEF_EQU        = 6;
  localparam int DEF_ACTIVE     = 0;
  localparam int DEF_ODD_PRE    = 502;
  localparam int DEF_ODD_POST   = 5;
  localparam int DEF_EVEN_PRE   = 503;
  localparam int DEF_EVEN_POST  = 4;
  localparam int DEF_HALF_WIDTH = 429;
  localparam int DEF_POLL_LINES = 64;
  // half-lines from a field boundary to the first poll of that field
  localparam int POLL_DELAY     = 15;

  typedef struct packed {
    logic lineRestart;   // counter is about to become even: new full line
  } seq_strobe_t;
endpackage

// File: rtl/hlseq_datapath.sv
module hlseq_datapath
  import hlseq_pkg::*;
#(
  parameter int EQU_W  = 4,
  parameter int ACV_W  = 10,
  parameter int BLK_W  = 10,
  parameter int HLW_W  = 10,
  parameter int POLL_W = 10,
  parameter int HC_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smpTick,
  input  logic              cfgWr,
  input  logic [EQU_W-1:0]  cfgEqu,
  input  logic [ACV_W-1:0]  cfgActive,
  input  logic [BLK_W-1:0]  cfgOddPre,
  input  logic [BLK_W-1:0]  cfgOddPost,
  input  logic [BLK_W-1:0]  cfgEvenPre,
  input  logic [BLK_W-1:0]  cfgEvenPost,
  input  logic [HLW_W-1:0]  cfgHalfWidth,
  input  logic [POLL_W-1:0] cfgPollLines,
  input  seq_strobe_t       strb,
  output logic [HC_W-1:0]   oddTot,
  output logic [HC_W-1:0]   frameTot,
  output logic [HC_W-1:0]   oddFirst,
  output logic [HC_W-1:0]   oddLast,
  output logic [HC_W-1:0]   evenFirst,
  output logic [HC_W-1:0]   evenLast,
  output logic [HC_W-1:0]   pollStep,
  output logic              actZero,
  output logic [HLW_W:0]    hPos
);
  localparam int HP_W = HLW_W + 1;

  logic [EQU_W-1:0]  equR;
  logic [ACV_W-1:0]  actR;
  logic [BLK_W-1:0]  oddPreR, oddPostR, evenPreR, evenPostR;
  logic [HLW_W-1:0]  hlwR;
  logic [POLL_W-1:0] pollR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      equR      <= EQU_W'(DEF_EQU);
      actR      <= ACV_W'(DEF_ACTIVE);
      oddPreR   <= BLK_W'(DEF_ODD_PRE);
      oddPostR  <= BLK_W'(DEF_ODD_POST);
      evenPreR  <= BLK_W'(DEF_EVEN_PRE);
      evenPostR <= BLK_W'(DEF_EVEN_POST);
      hlwR      <= HLW_W'(DEF_HALF_WIDTH);
      pollR     <= POLL_W'(DEF_POLL_LINES);
    end else if (cfgWr) begin
      equR      <= cfgEqu;
      actR      <= cfgActive;
      oddPreR   <= cfgOddPre;
      oddPostR  <= cfgOddPost;
      evenPreR  <= cfgEvenPre;
      evenPostR <= cfgEvenPost;
      hlwR      <= cfgHalfWidth;
      pollR     <= cfgPollLines;
    end
  end

  // field geometry, all in half-lines
  logic [HC_W-1:0] equHl, actHl, evenTot;
  always_comb begin
    equHl     = HC_W'(equR) * HC_W'(3);
    actHl     = HC_W'(actR) << 1;
    oddTot    = equHl + HC_W'(oddPreR) + actHl + HC_W'(oddPostR);
    evenTot   = equHl + HC_W'(evenPreR) + actHl + HC_W'(evenPostR);
    frameTot  = oddTot + evenTot;
    oddFirst  = equHl + HC_W'(oddPreR);
    oddLast   = oddFirst + actHl - HC_W'(1);
    evenFirst = equHl + HC_W'(evenPreR) + oddTot;
    evenLast  = evenFirst + actHl - HC_W'(1);
    pollStep  = HC_W'(pollR) << 1;
    actZero   = (actR == '0);
  end

  // horizontal position: samples since the current full line began
  logic [HP_W-1:0] smpCnt, twoHlw, cntInc;
  assign twoHlw = {hlwR, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               smpCnt <= '0;
    else if (strb.lineRestart)                smpCnt <= '0;
    else if (smpTick && (smpCnt < twoHlw))    smpCnt <= smpCnt + HP_W'(1);
  end

  always_comb begin
    cntInc = smpCnt + HP_W'(1);
    hPos   = (cntInc > twoHlw) ? twoHlw : cntInc;
    if (hPos == '0) hPos = HP_W'(1);
  end

  a_r8_pos_floor: assert property (@(posedge clk) disable iff (!rst_n)
    hPos != '0);
  a_r8_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lineRestart |=> (hPos == HP_W'(1)));
  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (twoHlw != '0) |-> (hPos <= twoHlw));
endmodule

// File: rtl/hlseq_ctrl.sv
module hlseq_ctrl
  import hlseq_pkg::*;
#(
  parameter int HC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hlTick,
  input  logic [HC_W-1:0] oddTot,
  input  logic [HC_W-1:0] frameTot,
  input  logic [HC_W-1:0] oddFirst,
  input  logic [HC_W-1:0] oddLast,
  input  logic [HC_W-1:0] evenFirst,
  input  logic [HC_W-1:0] evenLast,
  input  logic [HC_W-1:0] pollStep,
  input  logic            actZero,
  output logic [HC_W-1:0] hlCnt,
  output logic            fieldEven,
  output logic            fieldBegin,
  output logic            fieldEnd,
  output logic            eventEven,
  output logic            pollStrobe,
  output seq_strobe_t     strb
);
  logic [HC_W-1:0] nxt, nextPoll;
  logic begCond, endCond;

  always_comb begin
    nxt              = (hlCnt >= frameTot - HC_W'(1)) ? '0 : hlCnt + HC_W'(1);
    begCond          = !actZero && ((nxt == oddFirst) || (nxt == evenFirst));
    endCond          = !actZero && ((hlCnt == oddLast) || (hlCnt == evenLast));
    strb.lineRestart = hlTick && !nxt[0];
    fieldEven        = (hlCnt >= oddTot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hlCnt      <= '0;
      fieldBegin <= 1'b0;
      fieldEnd   <= 1'b0;
      eventEven  <= 1'b0;
      pollStrobe <= 1'b0;
      nextPoll   <= HC_W'(POLL_DELAY);
    end else begin
      fieldBegin <= hlTick && begCond;
      fieldEnd   <= hlTick && endCond;
      pollStrobe <= 1'b0;
      if (hlTick) begin
        hlCnt <= nxt;
        if (begCond)      eventEven <= (nxt == evenFirst);
        else if (endCond) eventEven <= (hlCnt == evenLast);
        if (nxt == '0)                nextPoll <= HC_W'(POLL_DELAY);
        else if (nxt == oddTot)       nextPoll <= oddTot + HC_W'(POLL_DELAY);
        else if (nxt == nextPoll) begin
          pollStrobe <= 1'b1;
          nextPoll   <= nextPoll + pollStep;
        end
      end
    end
  end

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !hlTick |=> $stable(hlCnt));
  a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    hlTick |=> ((hlCnt == '0) || (hlCnt == $past(hlCnt) + HC_W'(1))));
  a_r4_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (fieldBegin || fieldEnd) |-> $past(hlTick));
  a_r9_poll_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pollStrobe |-> $past(hlTick));
endmodule

// File: rtl/hlseq_top.sv
module hlseq_top
  import hlseq_pkg::*;
#(
  parameter int EQU_W  = 4,
  parameter int ACV_W  = 10,
  parameter int BLK_W  = 10,
  parameter int HLW_W  = 10,
  parameter int POLL_W = 10,
  parameter int HC_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hlTick,
  input  logic              smpTick,
  input  logic              cfgWr,
  input  logic [EQU_W-1:0]  cfgEqu,
  input  logic [ACV_W-1:0]  cfgActive,
  input  logic [BLK_W-1:0]  cfgOddPre,
  input  logic [BLK_W-1:0]  cfgOddPost,
  input  logic [BLK_W-1:0]  cfgEvenPre,
  input  logic [BLK_W-1:0]  cfgEvenPost,
  input  logic [HLW_W-1:0]  cfgHalfWidth,
  input  logic [POLL_W-1:0] cfgPollLines,
  output logic [HC_W-1:0]   halfLineIdx,
  output logic [HC_W-1:0]   vPos,
  output logic [HLW_W:0]    hPos,
  output logic              fieldEven,
  output logic              fieldBegin,
  output logic              fieldEnd,
  output logic              eventEven,
  output logic              pollStrobe
);
  seq_strobe_t strb;
  logic [HC_W-1:0] oddTot, frameTot, oddFirst, oddLast, evenFirst, evenLast, pollStep;
  logic actZero;

  hlseq_datapath #(
    .EQU_W(EQU_W), .ACV_W(ACV_W), .BLK_W(BLK_W),
    .HLW_W(HLW_W), .POLL_W(POLL_W), .HC_W(HC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .smpTick(smpTick), .cfgWr(cfgWr),
    .cfgEqu(cfgEqu), .cfgActive(cfgActive),
    .cfgOddPre(cfgOddPre), .cfgOddPost(cfgOddPost),
    .cfgEvenPre(cfgEvenPre), .cfgEvenPost(cfgEvenPost),
    .cfgHalfWidth(cfgHalfWidth), .cfgPollLines(cfgPollLines),
    .strb(strb),
    .oddTot(oddTot), .frameTot(frameTot),
    .oddFirst(oddFirst), .oddLast(oddLast),
    .evenFirst(evenFirst), .evenLast(evenLast),
    .pollStep(pollStep), .actZero(actZero), .hPos(hPos)
  );

  hlseq_ctrl #(.HC_W(HC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hlTick(hlTick),
    .oddTot(oddTot), .frameTot(frameTot),
    .oddFirst(oddFirst), .oddLast(oddLast),
    .evenFirst(evenFirst), .evenLast(evenLast),
    .pollStep(pollStep), .actZero(actZero),
    .hlCnt(halfLineIdx), .fieldEven(fieldEven),
    .fieldBegin(fieldBegin), .fieldEnd(fieldEnd),
    .eventEven(eventEven), .pollStrobe(pollStrobe), .strb(strb)
  );

  assign vPos = HC_W'(1) + (halfLineIdx >> 1);

  a_r7_vpos_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    vPos != '0);
endmodule

// File: tb/hlseq_top_tb.sv
module hlseq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hlTick = 1'b0, smpTick = 1'b0, cfgWr = 1'b0;
  logic [3:0] cfgEqu = '0;
  logic [9:0] cfgActive = '0, cfgOddPre = '0, cfgOddPost = '0;
  logic [9:0] cfgEvenPre = '0, cfgEvenPost = '0, cfgHalfWidth = '0, cfgPollLines = '0;
  logic [11:0] halfLineIdx, vPos;
  logic [10:0] hPos;
  logic fieldEven, fieldBegin, fieldEnd, eventEven, pollStrobe;

  int checks = 0;
  int failures = 0;
  int expCnt = 0;

  always #2 clk = ~clk;

  hlseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .hlTick(hlTick), .smpTick(smpTick), .cfgWr(cfgWr),
    .cfgEqu(cfgEqu), .cfgActive(cfgActive), .cfgOddPre(cfgOddPre), .cfgOddPost(cfgOddPost),
    .cfgEvenPre(cfgEvenPre), .cfgEvenPost(cfgEvenPost), .cfgHalfWidth(cfgHalfWidth),
    .cfgPollLines(cfgPollLines), .halfLineIdx(halfLineIdx), .vPos(vPos), .hPos(hPos),
    .fieldEven(fieldEven), .fieldBegin(fieldBegin), .fieldEnd(fieldEnd),
    .eventEven(eventEven), .pollStrobe(pollStrobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) hlTick = 1'b1;
    @(negedge clk) hlTick = 1'b0;
  endtask

  task automatic smp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) smpTick = 1'b1;
      @(negedge clk) smpTick = 1'b0;
    end
  endtask

  task automatic loadCfg(input int eq, input int act, input int op, input int opst,
                         input int ep, input int epst, input int hlw, input int n);
    @(negedge clk);
    cfgEqu = 4'(eq); cfgActive = 10'(act); cfgOddPre = 10'(op); cfgOddPost = 10'(opst);
    cfgEvenPre = 10'(ep); cfgEvenPost = 10'(epst); cfgHalfWidth = 10'(hlw);
    cfgPollLines = 10'(n); cfgWr = 1'b1;
    @(negedge clk) cfgWr = 1'b0;
  endtask

  function automatic bit pollDue(input int nxt, input int oTot, input int tot, input int n);
    int rel;
    if (nxt < oTot) rel = nxt - 15; else rel = nxt - oTot - 15;
    if (rel < 0 || nxt >= tot) return 0;
    if (nxt < oTot && nxt >= oTot) return 0;
    if (nxt < oTot && (15 >= oTot)) return 0;
    if (nxt >= oTot && (oTot + 15 >= tot)) return 0;
    if (n == 0) return rel == 0;
    return (rel % (2 * n)) == 0;
  endfunction

  // Run one full frame from count 0, checking every output on every tick.
  task automatic runFrame(input string tag, input int eq, input int act, input int op,
                          input int opst, input int ep, input int epst, input int n);
    int oTot, eTot, tot, oF, oL, eF, eL, cur, nxt;
    bit bExp, eExp;
    oTot = 3*eq + op + 2*act + opst;
    eTot = 3*eq + ep + 2*act + epst;
    tot = oTot + eTot;
    oF = 3*eq + op;  oL = oF + 2*act - 1;
    eF = 3*eq + ep + oTot;  eL = eF + 2*act - 1;
    for (int s = 0; s < tot; s++) begin
      cur = expCnt;
      nxt = (cur >= tot - 1) ? 0 : cur + 1;
      tick();
      expCnt = nxt;
      bExp = (act != 0) && (nxt == oF || nxt == eF);
      eExp = (act != 0) && (cur == oL || cur == eL);
      chk({tag, " R3 count"}, int'(halfLineIdx), nxt);
      chk({tag, " R2 field"}, int'(fieldEven), int'(nxt >= oTot));
      chk({tag, " R7 vpos"}, int'(vPos), 1 + nxt / 2);
      chk({tag, (act != 0) ? " R4 R5 begin" : " R6 begin"}, int'(fieldBegin), int'(bExp));
      chk({tag, (act != 0) ? " R4 R5 end" : " R6 end"}, int'(fieldEnd), int'(eExp));
      if (bExp) chk({tag, " R5 begin tag"}, int'(eventEven), int'(nxt == eF));
      else if (eExp) chk({tag, " R4 end tag"}, int'(eventEven), int'(cur == eL));
      chk({tag, " R9 poll"}, int'(pollStrobe), int'(pollDue(nxt, oTot, tot, n)));
    end
  endtask

  task automatic testReset();
    chk("R1 reset count", int'(halfLineIdx), 0);
    chk("R1 reset vpos", int'(vPos), 1);
    chk("R1 reset hpos", int'(hPos), 1);
    chk("R1 reset field", int'(fieldEven), 0);
    chk("R1 reset pulses", int'({fieldBegin, fieldEnd, pollStrobe}), 0);
  endtask

  task automatic testDefaults();
    for (int i = 0; i < 524; i++) tick();
    chk("R1 default odd span count", int'(halfLineIdx), 524);
    chk("R1 R2 default still odd", int'(fieldEven), 0);
    tick();
    chk("R1 R2 default even at 525", int'(fieldEven), 1);
    for (int i = 0; i < 524; i++) tick();
    chk("R1 default last index", int'(halfLineIdx), 1049);
    tick();
    chk("R1 R3 default wrap", int'(halfLineIdx), 0);
    expCnt = 0;
  endtask

  task automatic testMidFrameWrite();
    loadCfg(2, 8, 4, 3, 5, 2, 100, 4);
    for (int i = 0; i < 20; i++) tick();
    loadCfg(2, 8, 4, 0, 5, 2, 5, 4);
    chk("R10 write keeps count", int'(halfLineIdx), 20);
    chk("R10 write keeps field", int'(fieldEven), 0);
    for (int i = 0; i < 6; i++) tick();
    chk("R10 new odd total count", int'(halfLineIdx), 26);
    chk("R10 R2 new odd total field", int'(fieldEven), 1);
  endtask

  task automatic testHpos();
    chk("R8 home after even", int'(hPos), 1);
    smp(3);
    chk("R8 three samples", int'(hPos), 4);
    smp(20);
    chk("R8 clamp top", int'(hPos), 10);
    tick();
    chk("R8 odd half keeps", int'(hPos), 10);
    tick();
    chk("R8 even restarts", int'(hPos), 1);
    chk("R7 vpos at 28", int'(vPos), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testDefaults();
    loadCfg(2, 8, 4, 3, 5, 2, 100, 4);
    chk("R10 load at zero keeps count", int'(halfLineIdx), 0);
    runFrame("cfgA", 2, 8, 4, 3, 5, 2, 4);
    loadCfg(2, 0, 4, 3, 5, 2, 100, 4);
    runFrame("noAct", 2, 0, 4, 3, 5, 2, 4);
    loadCfg(3, 5, 6, 1, 7, 0, 100, 3);
    runFrame("cfgB", 3, 5, 6, 1, 7, 0, 3);
    testMidFrameWrite();
    testHpos();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule